// File: doc/BRIEF.md
# Raster Position Generator with Vertical-Blank Flag

This block tracks the beam position of a video processor whose dot clock runs at three times the host CPU rate. A dot counter steps once per dot clock. A scanline counter advances each time the dot counter wraps. At one exact raster position the block raises a vertical-blank flag, and at a later position it drops the flag again.

The CPU sees the flag as the top bit of a status register. The CPU reaches the register through a small read port. The CPU clock-enable strobe marks the single dot on which a CPU bus cycle is sampled. A status read clears the flag. A read on the very dot where the flag would rise returns zero and cancels the flag for that frame. An interrupt request output is high while the flag is set and interrupts are enabled.

The block is used next to the CPU bus decoder. The decoder passes in the low register-select bits of the CPU address, and the block returns the status byte on the cycle after the read is sampled.

Top module: `raster_vblank_timer`

## Requirements
- R1: While reset is high, and on the first cycle after it, the dot and line outputs are 0, `nmi` is 0 and `rd_data` is 0x00.
- R2: The dot counter counts 0 to DOTS_PER_LINE-1 (default 340). After the last dot it returns to 0 and the line counter increases by one.
- R3: After the last dot of line LINES_PER_FRAME-1 (default 261), both counters return to 0.
- R4: The flag rises at the clock edge that ends dot VBL_SET_DOT (default 1) of line VBL_SET_LINE (default 241). When the outputs still show that dot, `nmi` is 0. When they show the next dot, `nmi` is 1, provided `nmi_en` is 1.
- R5: A status read sampled on any dot before the set dot returns bit 7 = 0 and does not stop the flag from rising at the set dot. This includes the fourth cycle of a CPU instruction that began at dot 330 of the previous line.
- R6: The flag clears at the edge that ends dot VBL_CLR_DOT (default 1) of line VBL_CLR_LINE (default 261).
- R7: A read is accepted only on a cycle where `cpu_ce`, `rd_en` and `rd_addr` == 2 are all true. Any other combination leaves the flag and `rd_data` unchanged.
- R8: `nmi` is high exactly while the flag and `nmi_en` are both 1, and it follows `nmi_en` in the same cycle.
- R9: An accepted read loads `rd_data` on its edge. Bit 7 carries the flag, bits 6:0 are 0, and the value holds until the next accepted read.
- R10: An accepted read clears the flag on the same edge.
- R11: A read accepted on the set dot itself returns bit 7 = 0, and the flag stays 0 for the rest of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_ce | input | 1 | High on the dot where a CPU bus cycle is sampled |
| rd_en | input | 1 | CPU read strobe |
| rd_addr | input | ADDR_W | Register select (low CPU address bits); status is 2 |
| nmi_en | input | 1 | Interrupt enable control bit |
| rd_data | output | DATA_W | Status byte from the last accepted read |
| nmi | output | 1 | Interrupt request |
| dot | output | DOT_W | Current dot within the line |
| line | output | LINE_W | Current scanline |

## Verification
The position outputs show the dot that the next edge will process. So a flag event at position P becomes visible on `nmi` once the outputs show P+1. A read driven while the outputs show P returns its byte on `rd_data` one cycle later. A scoreboard queues each expected status byte when the read is issued. It compares the byte on the falling edge after the accepting rising edge. Flag checks on `nmi` are made on the falling edges where the outputs show the set dot, the clear dot and their successors. The race case is covered by reads aimed at the dot before, at and after the set dot.

// File: rtl/raster_pkg.sv
package raster_pkg;

    localparam int DEF_DOTS_PER_LINE  = 341;
    localparam int DEF_LINES_PER_FRAME = 262;
    localparam int DEF_VBL_SET_LINE   = 241;
    localparam int DEF_VBL_SET_DOT    = 1;
    localparam int DEF_VBL_CLR_LINE   = 261;
    localparam int DEF_VBL_CLR_DOT    = 1;
    localparam int DEF_STATUS_IDX     = 2;

    // Raster event decoded for the dot currently being processed
    typedef enum logic [1:0] {
        EVT_NONE  = 2'd0,
        EVT_SET   = 2'd1,
        EVT_CLEAR = 2'd2
    } flag_evt_e;

    // Status read request as seen by the flag logic
    typedef struct packed {
        logic hit;   // accepted status read on this edge
        logic race;  // read lands on the set dot
    } rd_req_t;

endpackage

// File: rtl/raster_counter.sv
module raster_counter #(
    parameter int DOTS_PER_LINE   = 341,
    parameter int LINES_PER_FRAME = 262,
    localparam int DOT_W  = $clog2(DOTS_PER_LINE),
    localparam int LINE_W = $clog2(LINES_PER_FRAME)
) (
    input  logic              clk,
    input  logic              rst,
    output logic [DOT_W-1:0]  dot,
    output logic [LINE_W-1:0] line
);
    localparam logic [DOT_W-1:0]  DOT_LAST  = DOT_W'(DOTS_PER_LINE - 1);
    localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES_PER_FRAME - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            dot  <= '0;
            line <= '0;
        end else if (dot == DOT_LAST) begin
            dot  <= '0;
            line <= (line == LINE_LAST) ? '0 : line + 1'b1;
        end else begin
            dot <= dot + 1'b1;
        end
    end
endmodule

// File: rtl/raster_event_decode.sv
module raster_event_decode
    import raster_pkg::*;
#(
    parameter int DOT_W        = 9,
    parameter int LINE_W       = 9,
    parameter int VBL_SET_LINE = 241,
    parameter int VBL_SET_DOT  = 1,
    parameter int VBL_CLR_LINE = 261,
    parameter int VBL_CLR_DOT  = 1
) (
    input  logic [DOT_W-1:0]  dot,
    input  logic [LINE_W-1:0] line,
    output flag_evt_e         evt
);
    logic at_set, at_clr;

    assign at_set = (dot == DOT_W'(VBL_SET_DOT)) && (line == LINE_W'(VBL_SET_LINE));
    assign at_clr = (dot == DOT_W'(VBL_CLR_DOT)) && (line == LINE_W'(VBL_CLR_LINE));

    always_comb begin
        evt = EVT_NONE;
        if (at_set)      evt = EVT_SET;
        else if (at_clr) evt = EVT_CLEAR;
    end
endmodule

// File: rtl/status_port.sv
module status_port
    import raster_pkg::*;
#(
    parameter int ADDR_W     = 3,
    parameter int DATA_W     = 8,
    parameter int STATUS_IDX = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_ce,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  flag_evt_e         evt,
    input  logic              flag,
    output rd_req_t           req,
    output logic [DATA_W-1:0] rd_data
);
    localparam int FLAG_BIT = DATA_W - 1;

    logic seen;

    assign req.hit  = cpu_ce && rd_en && (rd_addr == ADDR_W'(STATUS_IDX));
    assign req.race = req.hit && (evt == EVT_SET);
    // On the set dot the flag register is still 0, so the read sees 0
    assign seen     = flag && !req.race;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (req.hit) begin
            rd_data           <= '0;
            rd_data[FLAG_BIT] <= seen;
        end
    end
endmodule

// File: rtl/vblank_flag.sv
module vblank_flag
    import raster_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_evt_e evt,
    input  rd_req_t   req,
    output logic      flag
);
    // A read has priority: at the set dot it suppresses the rise
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (req.hit) begin
            flag <= 1'b0;
        end else begin
            unique case (evt)
                EVT_SET:   flag <= 1'b1;
                EVT_CLEAR: flag <= 1'b0;
                default:   flag <= flag;
            endcase
        end
    end
endmodule

// File: rtl/raster_vblank_timer.sv
module raster_vblank_timer
    import raster_pkg::*;
#(
    parameter int DOTS_PER_LINE   = DEF_DOTS_PER_LINE,
    parameter int LINES_PER_FRAME = DEF_LINES_PER_FRAME,
    parameter int VBL_SET_LINE    = DEF_VBL_SET_LINE,
    parameter int VBL_SET_DOT     = DEF_VBL_SET_DOT,
    parameter int VBL_CLR_LINE    = DEF_VBL_CLR_LINE,
    parameter int VBL_CLR_DOT     = DEF_VBL_CLR_DOT,
    parameter int ADDR_W          = 3,
    parameter int DATA_W          = 8,
    parameter int STATUS_IDX      = DEF_STATUS_IDX,
    localparam int DOT_W  = $clog2(DOTS_PER_LINE),
    localparam int LINE_W = $clog2(LINES_PER_FRAME)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_ce,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              nmi_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              nmi,
    output logic [DOT_W-1:0]  dot,
    output logic [LINE_W-1:0] line
);
    flag_evt_e evt;
    rd_req_t   req;
    logic      flag;

    raster_counter #(
        .DOTS_PER_LINE  (DOTS_PER_LINE),
        .LINES_PER_FRAME(LINES_PER_FRAME)
    ) u_cnt (
        .clk (clk),
        .rst (rst),
        .dot (dot),
        .line(line)
    );

    raster_event_decode #(
        .DOT_W       (DOT_W),
        .LINE_W      (LINE_W),
        .VBL_SET_LINE(VBL_SET_LINE),
        .VBL_SET_DOT (VBL_SET_DOT),
        .VBL_CLR_LINE(VBL_CLR_LINE),
        .VBL_CLR_DOT (VBL_CLR_DOT)
    ) u_dec (
        .dot (dot),
        .line(line),
        .evt (evt)
    );

    status_port #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .STATUS_IDX(STATUS_IDX)
    ) u_port (
        .clk    (clk),
        .rst    (rst),
        .cpu_ce (cpu_ce),
        .rd_en  (rd_en),
        .rd_addr(rd_addr),
        .evt    (evt),
        .flag   (flag),
        .req    (req),
        .rd_data(rd_data)
    );

    vblank_flag u_flag (
        .clk (clk),
        .rst (rst),
        .evt (evt),
        .req (req),
        .flag(flag)
    );

    assign nmi = flag && nmi_en;
endmodule

// File: rtl/raster_vblank_checker.sv
module raster_vblank_checker #(
    parameter int DOTS_PER_LINE   = 341,
    parameter int LINES_PER_FRAME = 262,
    parameter int VBL_SET_LINE    = 241,
    parameter int VBL_SET_DOT     = 1,
    parameter int VBL_CLR_LINE    = 261,
    parameter int VBL_CLR_DOT     = 1,
    parameter int ADDR_W          = 3,
    parameter int DATA_W          = 8,
    parameter int STATUS_IDX      = 2,
    parameter int DOT_W           = 9,
    parameter int LINE_W          = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_ce,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              nmi_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              nmi,
    input logic [DOT_W-1:0]  dot,
    input logic [LINE_W-1:0] line
);
    logic acc_rd;
    assign acc_rd = cpu_ce && rd_en && (rd_addr == ADDR_W'(STATUS_IDX));

    AST_DOT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(dot) < DOTS_PER_LINE);  // R2

    AST_DOT_STEP: assert property (@(posedge clk) disable iff (rst)
        (int'(dot) != DOTS_PER_LINE - 1) |=> (dot == $past(dot) + 1'b1));  // R2

    AST_LINE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(line) < LINES_PER_FRAME);  // R3

    AST_NMI_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        nmi |-> nmi_en);  // R8

    AST_NMI_RISE_POS: assert property (@(posedge clk) disable iff (rst)
        $rose(nmi) |-> ($rose(nmi_en) ||
            (int'($past(line)) == VBL_SET_LINE && int'($past(dot)) == VBL_SET_DOT)));  // R4

    AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (int'(line) == VBL_CLR_LINE && int'(dot) == VBL_CLR_DOT) |=> !nmi);  // R6

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        acc_rd |=> !nmi);  // R10

    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_data[DATA_W-2:0] == '0);  // R9

    AST_HOLD_NO_READ: assert property (@(posedge clk) disable iff (rst)
        !acc_rd |=> $stable(rd_data));  // R7
endmodule

bind raster_vblank_timer raster_vblank_checker #(
    .DOTS_PER_LINE  (DOTS_PER_LINE),
    .LINES_PER_FRAME(LINES_PER_FRAME),
    .VBL_SET_LINE   (VBL_SET_LINE),
    .VBL_SET_DOT    (VBL_SET_DOT),
    .VBL_CLR_LINE   (VBL_CLR_LINE),
    .VBL_CLR_DOT    (VBL_CLR_DOT),
    .ADDR_W         (ADDR_W),
    .DATA_W         (DATA_W),
    .STATUS_IDX     (STATUS_IDX),
    .DOT_W          (DOT_W),
    .LINE_W         (LINE_W)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .cpu_ce (cpu_ce),
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .nmi_en (nmi_en),
    .rd_data(rd_data),
    .nmi    (nmi),
    .dot    (dot),
    .line   (line)
);

// File: tb/raster_vblank_timer_tb.sv
`timescale 1ns/1ps
module raster_vblank_timer_tb;
    localparam int DOTS   = 341;
    localparam int LINES  = 30;   // short frame keeps several frames in budget
    localparam int SET_L  = 20;
    localparam int SET_D  = 1;
    localparam int CLR_L  = 29;
    localparam int CLR_D  = 1;
    localparam int DOT_W  = $clog2(DOTS);
    localparam int LINE_W = $clog2(LINES);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cpu_ce = 1'b0;
    logic              rd_en = 1'b0;
    logic [2:0]        rd_addr = 3'd0;
    logic              nmi_en = 1'b0;
    logic [7:0]        rd_data;
    logic              nmi;
    logic [DOT_W-1:0]  dot;
    logic [LINE_W-1:0] line;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_q[$];
    string      req_q[$];

    always #2.5 clk = ~clk;

    raster_vblank_timer #(
        .DOTS_PER_LINE  (DOTS),
        .LINES_PER_FRAME(LINES),
        .VBL_SET_LINE   (SET_L),
        .VBL_SET_DOT    (SET_D),
        .VBL_CLR_LINE   (CLR_L),
        .VBL_CLR_DOT    (CLR_D)
    ) u_dut (
        .clk(clk), .rst(rst), .cpu_ce(cpu_ce), .rd_en(rd_en), .rd_addr(rd_addr),
        .nmi_en(nmi_en), .rd_data(rd_data), .nmi(nmi), .dot(dot), .line(line)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at line %0d dot %0d",
                     req, act, exp, line, dot);
        end
    endtask

    task automatic goto(input int l, input int d);
        while (!(int'(line) == l && int'(dot) == d)) @(negedge clk);
    endtask

    // Driver: queue expected byte, issue one accepted status read
    task automatic cpu_read(input string req, input logic [7:0] exp);
        exp_q.push_back(exp);
        req_q.push_back(req);
        cpu_ce = 1'b1; rd_en = 1'b1; rd_addr = 3'd2;
        @(negedge clk);
        cpu_ce = 1'b0; rd_en = 1'b0; rd_addr = 3'd0;
    endtask

    task automatic cpu_idle_cycle();
        cpu_ce = 1'b1;
        @(negedge clk);
        cpu_ce = 1'b0;
    endtask

    // Monitor: a read accepted at a rising edge is compared one half cycle later
    initial begin
        forever begin
            @(posedge clk);
            if (!rst && cpu_ce && rd_en && rd_addr == 3'd2) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    check("R9", 1, 0);
                end else begin
                    check(req_q.pop_front(), int'(rd_data), int'(exp_q.pop_front()));
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", int'(dot), 0);
        check("R1", int'(nmi), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", int'(rd_data), 0);
        check("R1", int'(line), 0);
        nmi_en = 1'b1;

        // R2: dot wrap advances line
        goto(0, DOTS - 1);
        @(negedge clk);
        check("R2", int'(dot), 0);
        check("R2", int'(line), 1);

        // R5: instruction starting at dot 330, status read on its 4th cycle
        goto(SET_L - 1, 330); cpu_idle_cycle();
        goto(SET_L - 1, 333); cpu_idle_cycle();
        goto(SET_L - 1, 336); cpu_idle_cycle();
        goto(SET_L - 1, 339); cpu_read("R5", 8'h00);

        // R4: flag visible one dot after the set dot
        goto(SET_L, SET_D);
        check("R4", int'(nmi), 0);
        @(negedge clk);
        check("R4", int'(nmi), 1);

        // R7: reads without strobe or to another register are ignored
        goto(SET_L, 20);
        rd_en = 1'b1; rd_addr = 3'd2;
        @(negedge clk);
        rd_en = 1'b0;
        goto(SET_L, 22);
        cpu_ce = 1'b1; rd_en = 1'b1; rd_addr = 3'd3;
        @(negedge clk);
        cpu_ce = 1'b0; rd_en = 1'b0; rd_addr = 3'd0;
        @(negedge clk);
        check("R7", int'(nmi), 1);
        check("R7", int'(rd_data), 0);

        // R8: nmi follows the enable
        goto(SET_L, 40);
        nmi_en = 1'b0;
        #0.1 check("R8", int'(nmi), 0);
        @(negedge clk);
        nmi_en = 1'b1;
        #0.1 check("R8", int'(nmi), 1);

        // R6: line clear
        goto(CLR_L, CLR_D);
        check("R6", int'(nmi), 1);
        @(negedge clk);
        check("R6", int'(nmi), 0);
        goto(CLR_L, 10); cpu_read("R6", 8'h00);

        // R3: frame wrap
        goto(LINES - 1, DOTS - 1);
        @(negedge clk);
        check("R3", int'(line), 0);
        check("R3", int'(dot), 0);

        // R9/R10: readback then clear by read (frame 1)
        goto(SET_L, 30); cpu_read("R9", 8'h80);
        check("R10", int'(nmi), 0);
        goto(SET_L, 40); cpu_read("R10", 8'h00);

        // R11: read on the set dot (frame 2)
        goto(LINES - 1, DOTS - 1); @(negedge clk);
        goto(SET_L, SET_D); cpu_read("R11", 8'h00);
        check("R11", int'(nmi), 0);
        goto(SET_L, 10); cpu_read("R11", 8'h00);

        // R9: read one dot after the set dot sees the flag (frame 3)
        goto(LINES - 1, DOTS - 1); @(negedge clk);
        goto(SET_L, SET_D + 1); cpu_read("R9", 8'h80);
        repeat (2) @(negedge clk);
        check("R9", int'(rd_data), 8'h80);
        check("R9", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule